// File: doc/BRIEF.md
# Carry-Select Binary Incrementer

This block adds one to a 16-bit word in pure combinational logic and reports the carry that leaves the top bit. An enable input serves as the carry into the least significant bits. When the enable is low, the word passes through unchanged.

The word is cut into four slices of four bits each. The lowest slice is incremented directly. Every higher slice prepares two results ahead of time: its bits as they are, and its bits plus one. A 2-to-1 multiplexer then picks one of the two using the carry that arrives from the slices below. That carry is the enable ANDed with one all-ones flag per lower slice. Because each slice's own add chain is only four bits long, no ripple path runs across the whole word. The block can sit in a larger datapath wherever a fast +1 is needed, such as an address or count update, and needs no clock.

Top module: `cs_incr`

## Requirements
- R1: With `inc_en` = 1, the value {`carry_out`, `sum_out`} equals `din` + 1 as a 17-bit number.
- R2: With `inc_en` = 0, `sum_out` equals `din` and `carry_out` is 0.
- R3: `carry_out` is 1 exactly when `inc_en` = 1 and all 16 bits of `din` are 1. In that case `sum_out` is zero.
- R4: Bits 3:0 of `sum_out` equal bits 3:0 of `din` plus `inc_en`, modulo 16, whatever the upper bits hold. With `inc_en` = 1, bit 0 of the result is always the inverse of bit 0 of the input.
- R5: For each slice g (bits 4g+3 down to 4g), the output slice equals the input slice plus a slice carry, modulo 16. The slice carry is 1 only when `inc_en` = 1 and every input bit below bit 4g is 1. Otherwise the slice passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| inc_en | input | 1 | Carry into the lowest slice; 0 makes the block a pass-through |
| din | input | 16 | Word to increment |
| sum_out | output | 16 | Incremented word, modulo 2^16 |
| carry_out | output | 1 | Carry leaving the most significant slice |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus, with zero register stages on the way. The bench drives a new input just after a rising edge and samples the outputs at the following falling edge, once the logic has settled and well before the next change. It sweeps all 2^17 combinations of word and enable. For each combination it compares the full sum, the carry and each slice against values derived arithmetically from the sum and from the all-ones condition of the lower bits.

// File: rtl/cs_incr.sv
module cs_incr #(
  parameter int WIDTH  = 16,
  parameter int GROUPS = 4
) (
  input  logic             inc_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sum_out,
  output logic             carry_out
);
  localparam int GW = WIDTH / GROUPS;

  logic [GROUPS:0]   gcarry;
  logic [GROUPS-1:0] all_ones;

  assign gcarry[0] = inc_en;

  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    logic [GW-1:0] slice_in;
    assign slice_in    = din[g*GW +: GW];
    assign all_ones[g] = &slice_in;
    assign gcarry[g+1] = gcarry[g] & all_ones[g];

    if (g == 0) begin : g_base
      assign sum_out[GW-1:0] = slice_in + GW'(inc_en);
    end else begin : g_select
      logic [GW-1:0] plus_one;
      assign plus_one            = slice_in + GW'(1);
      assign sum_out[g*GW +: GW] = gcarry[g] ? plus_one : slice_in;
    end
  end

  assign carry_out = gcarry[GROUPS];

  always_comb begin
    if (!$isunknown({inc_en, din})) begin
      if (inc_en)
        p_sum_r1: assert ({carry_out, sum_out} == {1'b0, din} + (WIDTH+1)'(1))
          else $error("R1 sum mismatch");
      if (!inc_en)
        p_hold_r2: assert (sum_out == din && !carry_out)
          else $error("R2 pass-through mismatch");
      p_carry_r3: assert (carry_out == (inc_en && din == {WIDTH{1'b1}}))
        else $error("R3 carry mismatch");
      if (carry_out)
        p_wrap_r3: assert (sum_out == '0)
          else $error("R3 wrap mismatch");
      if (inc_en)
        p_lsb_r4: assert (sum_out[0] != din[0])
          else $error("R4 lsb did not toggle");
    end
  end
endmodule

// File: tb/cs_incr_bench.sv
module cs_incr_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inc_en;
  logic [15:0] din;
  logic [15:0] sum_out;
  logic        carry_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cs_incr u_cs_incr (
    .inc_en(inc_en),
    .din(din),
    .sum_out(sum_out),
    .carry_out(carry_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s din=%h en=%b actual=%h expected=%h", req, din, inc_en, act, exp);
    end
  endtask

  task automatic check_vector();
    logic [16:0] full;
    full = {1'b0, din} + 17'(inc_en);
    if (inc_en) chk("R1", {15'd0, carry_out, sum_out}, {15'd0, full});
    else        chk("R2", {15'd0, carry_out, sum_out}, {16'd0, din});
    chk("R3", {31'd0, carry_out}, {31'd0, inc_en && din == 16'hFFFF});
    if (carry_out) chk("R3", {16'd0, sum_out}, 32'd0);
    chk("R4", {28'd0, sum_out[3:0]}, {28'd0, 4'(din[3:0] + 4'(inc_en))});
    for (int g = 1; g < 4; g++) begin
      int unsigned lowmask;
      bit cin;
      lowmask = (32'd1 << (4 * g)) - 1;
      cin = inc_en && ((32'(din) & lowmask) == lowmask);
      chk("R5", {28'd0, sum_out[g*4 +: 4]}, {28'd0, 4'(din[g*4 +: 4] + 4'(cin))});
    end
  endtask

  initial begin
    inc_en = 1'b0;
    din    = 16'h0000;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R2", {15'd0, carry_out, sum_out}, 32'd0);
    for (int e = 0; e < 2; e++) begin
      for (int v = 0; v < 65536; v++) begin
        @(posedge clk);
        inc_en = e[0];
        din    = v[15:0];
        @(negedge clk);
        check_vector();
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule